// File: doc/BRIEF.md
# Chainable Byte Adder-Subtractor with Flags

This block adds or subtracts two 8-bit operands and reports the result together with carry, signed overflow, zero and half-carry flags. Subtraction reuses the adder: every bit of the second operand is complemented by XOR with the subtract select. The missing "+1" of the two's complement enters through the carry input of the lowest adder slice. The datapath is two 4-bit ripple slices in cascade. The low slice's carry out drives the high slice's carry in.

For values wider than a byte, a chain select routes an external carry line into the adder, and the carry flag of one byte is fed back as the carry input of the next. A build parameter sets the meaning of that line on subtract. In normalised mode a 1 always means "carry on add, borrow on subtract". In raw mode the adder carry out passes through unchanged, so on subtract a 0 means borrow. The result and flags are captured in an output register when the load enable is high.

Top module: `addsub_unit`

## Requirements
- R1: With sub_i=0 and chain_i=0, a load produces res_o = (a_i + b_i) mod 256 on the next rising clock edge.
- R2: With sub_i=1 and chain_i=0, a load produces res_o = (a_i - b_i) mod 256, formed as a_i + ~b_i + 1.
- R3: On an unchained add, carry_o is 1 exactly when a_i + b_i exceeds 255, in both polarity modes.
- R4: With BORROW_NORM=1, carry_o after a subtract is 1 exactly when a borrow occurred, i.e. the unsigned minuend was smaller than the subtrahend plus the incoming borrow.
- R5: With BORROW_NORM=0, carry_o after a subtract is the raw adder carry out: 0 means a borrow occurred.
- R6: ovf_o is 1 exactly when the two's-complement result of the signed operation lies outside -128..127. It is not taken from carry_o.
- R7: zero_o is 1 exactly when res_o is 0; an unchained subtract of equal operands sets zero_o and clears ovf_o.
- R8: half_o is the carry from bit 3 into bit 4 of the adder, with b_i already complemented on subtract.
- R9: With chain_i=1, the adder carry-in is sub_i XOR cin_i when BORROW_NORM=1, and cin_i when BORROW_NORM=0. Feeding carry_o of a low byte into cin_i of the high byte gives correct 16-bit sums and differences.
- R10: With chain_i=0, cin_i has no effect on any output.
- R11: While load_i is 0, res_o and all flags keep their values whatever the other inputs do.
- R12: While rst_ni is 0, res_o and all flags are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| load_i | input | 1 | Capture result and flags on this edge |
| a_i | input | 8 | First operand (minuend) |
| b_i | input | 8 | Second operand (subtrahend) |
| sub_i | input | 1 | 1 = subtract, 0 = add |
| chain_i | input | 1 | 1 = use cin_i as carry/borrow in |
| cin_i | input | 1 | External carry or borrow, polarity per BORROW_NORM |
| res_o | output | 8 | Registered result |
| carry_o | output | 1 | Carry / borrow flag |
| ovf_o | output | 1 | Signed overflow flag |
| zero_o | output | 1 | Result-is-zero flag |
| half_o | output | 1 | Carry out of bit 3 |

## Verification
The only internal state is the output register, so a wrong captured value shows at the ports one edge after the load. Faults in the combinational path (a broken slice cascade, a wrong carry-in mux or an inverted flag) need particular operand pairs before they show. For this reason every operand pair is applied in both add and subtract to both polarity builds, and each is compared against an arithmetic model written from integer sums, not from gate equations. Chained 16-bit sequences expose carry-line polarity faults only on the high byte, one load after the low byte.

// File: rtl/addsub_pkg.sv
package addsub_pkg;
  typedef struct packed {
    logic carry;
    logic ovf;
    logic zero;
    logic half;
  } flags_t;
endpackage

// File: rtl/addsub_slice.sv
module addsub_slice #(
  parameter int W = 4
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         c_i,
  output logic [W-1:0] s_o,
  output logic         c_o
);
  logic [W:0] c;
  assign c[0] = c_i;
  for (genvar i = 0; i < W; i++) begin : g_bit
    assign s_o[i]  = a_i[i] ^ b_i[i] ^ c[i];
    assign c[i+1]  = (a_i[i] & b_i[i]) | (c[i] & (a_i[i] ^ b_i[i]));
  end
  assign c_o = c[W];
endmodule

// File: rtl/addsub_carry_ctrl.sv
module addsub_carry_ctrl #(
  parameter bit BORROW_NORM = 1'b1
) (
  input  logic sub_i,
  input  logic chain_i,
  input  logic cin_i,
  input  logic cout_i,
  output logic cin_eff_o,
  output logic carry_o
);
  always_comb begin
    if (!chain_i)         cin_eff_o = sub_i;
    else if (BORROW_NORM) cin_eff_o = sub_i ^ cin_i;
    else                  cin_eff_o = cin_i;
  end
  // normalised: 1 = carry on add, borrow on subtract
  assign carry_o = BORROW_NORM ? (cout_i ^ sub_i) : cout_i;
endmodule

// File: rtl/addsub_flag_gen.sv
module addsub_flag_gen #(
  parameter int W = 8
) (
  input  logic [W-1:0]           sum_i,
  input  logic                   a_msb_i,
  input  logic                   bx_msb_i,
  input  logic                   cout_i,
  input  logic                   carry_i,
  input  logic                   half_i,
  output addsub_pkg::flags_t     flags_o
);
  logic c_into_msb;
  assign c_into_msb    = sum_i[W-1] ^ a_msb_i ^ bx_msb_i;
  assign flags_o.carry = carry_i;
  assign flags_o.ovf   = c_into_msb ^ cout_i;
  assign flags_o.zero  = ~|sum_i;
  assign flags_o.half  = half_i;
endmodule

// File: rtl/addsub_unit.sv
module addsub_unit #(
  parameter int WIDTH       = 8,
  parameter int SLICE_W     = 4,
  parameter bit BORROW_NORM = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             sub_i,
  input  logic             chain_i,
  input  logic             cin_i,
  output logic [WIDTH-1:0] res_o,
  output logic             carry_o,
  output logic             ovf_o,
  output logic             zero_o,
  output logic             half_o
);
  import addsub_pkg::*;
  localparam int NSL = WIDTH / SLICE_W;

  logic [WIDTH-1:0] b_x, sum;
  logic [NSL:0]     c_chain;
  logic             carry_flag;
  flags_t           flags_d, flags_q;
  logic [WIDTH-1:0] res_q;

  assign b_x = b_i ^ {WIDTH{sub_i}};

  addsub_carry_ctrl #(.BORROW_NORM(BORROW_NORM)) u_cctl (
    .sub_i    (sub_i),
    .chain_i  (chain_i),
    .cin_i    (cin_i),
    .cout_i   (c_chain[NSL]),
    .cin_eff_o(c_chain[0]),
    .carry_o  (carry_flag)
  );

  for (genvar k = 0; k < NSL; k++) begin : g_slice
    addsub_slice #(.W(SLICE_W)) u_slice (
      .a_i(a_i[k*SLICE_W +: SLICE_W]),
      .b_i(b_x[k*SLICE_W +: SLICE_W]),
      .c_i(c_chain[k]),
      .s_o(sum[k*SLICE_W +: SLICE_W]),
      .c_o(c_chain[k+1])
    );
  end

  addsub_flag_gen #(.W(WIDTH)) u_flags (
    .sum_i   (sum),
    .a_msb_i (a_i[WIDTH-1]),
    .bx_msb_i(b_x[WIDTH-1]),
    .cout_i  (c_chain[NSL]),
    .carry_i (carry_flag),
    .half_i  (c_chain[1]),
    .flags_o (flags_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_q   <= '0;
      flags_q <= '0;
    end else if (load_i) begin
      res_q   <= sum;
      flags_q <= flags_d;
    end
  end

  assign res_o   = res_q;
  assign carry_o = flags_q.carry;
  assign ovf_o   = flags_q.ovf;
  assign zero_o  = flags_q.zero;
  assign half_o  = flags_q.half;
endmodule

// File: rtl/addsub_chk.sv
module addsub_chk #(
  parameter int WIDTH = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             load_i,
  input logic [WIDTH-1:0] a_i,
  input logic [WIDTH-1:0] b_i,
  input logic             sub_i,
  input logic             chain_i,
  input logic [WIDTH-1:0] res_o,
  input logic             carry_o,
  input logic             ovf_o,
  input logic             zero_o,
  input logic             half_o
);
  assert_add_sum_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i && !sub_i && !chain_i |=> res_o == WIDTH'($past(a_i) + $past(b_i)));

  assert_sub_diff_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i && sub_i && !chain_i |=> res_o == WIDTH'($past(a_i) - $past(b_i)));

  assert_add_carry_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i && !sub_i && !chain_i |=> carry_o == ($past(a_i) > ~$past(b_i)));

  assert_add_ovf_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i && !sub_i && !chain_i |=>
      ovf_o == (($past(a_i[WIDTH-1]) == $past(b_i[WIDTH-1])) &&
                (res_o[WIDTH-1] != $past(a_i[WIDTH-1]))));

  assert_eq_zero_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i && sub_i && !chain_i && (a_i == b_i) |=> zero_o && !ovf_o);

  assert_add_half_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i && !sub_i && !chain_i |=> half_o == ($past(a_i[3:0]) > ~$past(b_i[3:0])));

  assert_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(res_o) && $stable(carry_o) && $stable(ovf_o) &&
                $stable(zero_o) && $stable(half_o));
endmodule

bind addsub_unit addsub_chk #(.WIDTH(WIDTH)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .load_i (load_i),
  .a_i    (a_i),
  .b_i    (b_i),
  .sub_i  (sub_i),
  .chain_i(chain_i),
  .res_o  (res_o),
  .carry_o(carry_o),
  .ovf_o  (ovf_o),
  .zero_o (zero_o),
  .half_o (half_o)
);

// File: tb/sim_addsub_unit.sv
module sim_addsub_unit;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_ni = 1'b0, load = 1'b0;
  logic [7:0] a = '0, b = '0;
  logic sub = 1'b0, chain = 1'b0, cin0 = 1'b0, cin1 = 1'b0;
  logic [7:0] res0, res1;
  logic c0, v0, z0, h0, c1, v1, z1, h1;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  addsub_unit #(.BORROW_NORM(1'b1)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .load_i(load), .a_i(a), .b_i(b),
    .sub_i(sub), .chain_i(chain), .cin_i(cin0),
    .res_o(res0), .carry_o(c0), .ovf_o(v0), .zero_o(z0), .half_o(h0));

  addsub_unit #(.BORROW_NORM(1'b0)) u1 (
    .clk_i(clk), .rst_ni(rst_ni), .load_i(load), .a_i(a), .b_i(b),
    .sub_i(sub), .chain_i(chain), .cin_i(cin1),
    .res_o(res1), .carry_o(c1), .ovf_o(v1), .zero_o(z1), .half_o(h1));

  task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %0h exp %0h", tag, got, exp);
    end
  endtask

  task automatic model(input logic [7:0] ma, input logic [7:0] mb, input logic s,
                       input logic ch, input logic ci, input logic norm,
                       output logic [7:0] r, output logic cy, output logic v,
                       output logic z, output logic h);
    int ce, full, sr;
    ce = !ch ? int'(s) : (norm ? int'(s ^ ci) : int'(ci));
    if (!s) begin
      full = int'(ma) + int'(mb) + ce;
      cy   = full > 255;
      sr   = int'($signed(ma)) + int'($signed(mb)) + ce;
      h    = (int'(ma[3:0]) + int'(mb[3:0]) + ce) > 15;
    end else begin
      full = int'(ma) - int'(mb) - (1 - ce);
      cy   = norm ? (full < 0) : !(full < 0);
      sr   = int'($signed(ma)) - int'($signed(mb)) - (1 - ce);
      h    = (int'(ma[3:0]) + (15 - int'(mb[3:0])) + ce) > 15;
    end
    r = full[7:0];
    v = (sr > 127) || (sr < -128);
    z = (r == 8'h00);
  endtask

  // called at a negedge; drives, loads, samples at the following negedge
  task automatic run_vec(input logic [7:0] ta, input logic [7:0] tb, input logic s,
                         input logic ch, input logic ci0, input logic ci1);
    logic [7:0] r; logic cy, v, z, h;
    string rt, ct;
    a = ta; b = tb; sub = s; chain = ch; cin0 = ci0; cin1 = ci1; load = 1'b1;
    @(negedge clk);
    rt = ch ? "R9" : (s ? "R2" : "R1");
    model(ta, tb, s, ch, ci0, 1'b1, r, cy, v, z, h);
    ct = ch ? "R9" : (s ? "R4" : "R3");
    chk(rt, 16'(res0), 16'(r));
    chk(ct, 16'(c0), 16'(cy));
    chk("R6", 16'(v0), 16'(v));
    chk("R7", 16'(z0), 16'(z));
    chk("R8", 16'(h0), 16'(h));
    model(ta, tb, s, ch, ci1, 1'b0, r, cy, v, z, h);
    ct = ch ? "R9" : (s ? "R5" : "R3");
    chk(rt, 16'(res1), 16'(r));
    chk(ct, 16'(c1), 16'(cy));
    chk("R6", 16'(v1), 16'(v));
    chk("R7", 16'(z1), 16'(z));
    chk("R8", 16'(h1), 16'(h));
  endtask

  task automatic t_reset();
    chk("R12", 16'(res0), 16'h0);
    chk("R12", {12'h0, c0, v0, z0, h0}, 16'h0);
    chk("R12", {12'h0, c1, v1, z1, h1}, 16'h0);
  endtask

  task automatic t_corners();
    run_vec(8'd127, 8'd1, 1'b0, 1'b0, 1'b0, 1'b0);
    chk("R6", 16'(v0), 16'h1);
    chk("R3", 16'(c0), 16'h0);
    run_vec(8'd0, 8'd1, 1'b1, 1'b0, 1'b0, 1'b0);
    chk("R4", 16'(c0), 16'h1);
    chk("R5", 16'(c1), 16'h0);
    run_vec(8'd77, 8'd77, 1'b1, 1'b0, 1'b0, 1'b0);
    chk("R7", {14'h0, z0, z1}, 16'h3);
    run_vec(8'd15, 8'd1, 1'b0, 1'b0, 1'b0, 1'b0);
    chk("R8", 16'(h0), 16'h1);
    run_vec(8'd5, 8'd3, 1'b0, 1'b0, 1'b1, 1'b1);
    chk("R10", 16'(res0), 16'd8);
    chk("R10", 16'(res1), 16'd8);
  endtask

  task automatic t_hold();
    run_vec(8'd10, 8'd20, 1'b0, 1'b0, 1'b0, 1'b0);
    load = 1'b0; a = 8'd99; b = 8'd200; sub = 1'b1;
    @(negedge clk);
    chk("R11", 16'(res0), 16'd30);
    chk("R11", 16'(res1), 16'd30);
    chk("R11", {12'h0, c0, v0, z0, h0}, 16'h0);
  endtask

  task automatic t_exhaustive();
    for (int i = 0; i < 256; i++)
      for (int j = 0; j < 256; j++)
        for (int s = 0; s < 2; s++)
          run_vec(8'(i), 8'(j), s[0], 1'b0, 1'(i), 1'(j));
  endtask

  task automatic t_chain16();
    for (int n = 0; n < 100; n++) begin
      logic [15:0] xa, xb, ex;
      logic [7:0] lo0, lo1;
      logic s, bo;
      xa = 16'($urandom); xb = 16'($urandom); s = 1'($urandom);
      run_vec(xa[7:0], xb[7:0], s, 1'b1, 1'b0, s);
      lo0 = res0; lo1 = res1;
      run_vec(xa[15:8], xb[15:8], s, 1'b1, c0, c1);
      ex = s ? (xa - xb) : (xa + xb);
      bo = s ? (xa < xb) : ((32'(xa) + 32'(xb)) > 32'hFFFF);
      chk("R9", {res0, lo0}, ex);
      chk("R9", {res1, lo1}, ex);
      chk("R9", 16'(c0), 16'(bo));
      chk("R9", 16'(c1), s ? 16'(!bo) : 16'(bo));
    end
  endtask

  task automatic t_mid_reset();
    run_vec(8'd200, 8'd100, 1'b0, 1'b0, 1'b0, 1'b0);
    rst_ni = 1'b0;
    #1;
    t_reset();
    @(negedge clk);
    rst_ni = 1'b1;
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_ni = 1'b1;
    @(negedge clk);
    t_corners();
    t_hold();
    t_exhaustive();
    t_chain16();
    t_mid_reset();
    done = 1'b1;
    finish_run();
  end

  initial begin
    repeat (195000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog R1 got hung exp done");
      finish_run();
    end
  end
endmodule